// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block runs the bus cycles for one DMA channel after the channel has won arbitration and the processor has released the buses. It begins when `start` is seen while idle. At that point it latches the transfer kind, the address direction, the source and destination addresses and the word count. It then steps each word through four phases: address out, read command, write command and release. A wait phase is added while the `ready` input is low.

The low address byte goes out on `addr_lo`. The high address byte goes out on the shared data bus during the address phase, together with a one-cycle `adstb` pulse that loads an external latch. Four transfer kinds are supported: verify, DMA write (peripheral to memory), DMA read (memory to peripheral) and memory-to-memory copy. A copy takes two passes per word. The first pass reads the source byte into an internal holding register. The second pass writes that byte back out on the data bus to the destination address.

The pads themselves are not modelled. Separate output enables tell the pad ring when to drive the data bus and the I/O strobe lines. The I/O strobe lines act as inputs whenever the block is idle.

Top module: `dma_xfer_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, the block is idle. In that state `busy`, `io_oe`, `db_oe`, `adstb` and `tc` are 0 and all four active-low strobes are 1.
- R2: The first cycle of every pass (the address phase) has the following outputs:
  - `adstb` is 1, for exactly one cycle.
  - `db_oe` is 1 and `db_out` carries address bits 15..8.
  - `addr_lo` carries address bits 7..0.
  - No strobe is active.
- R3: Kind 1 (DMA write) pulls `ior_n` low in the second and third phases and in any wait cycles. It pulls `memw_n` low in the third phase and in any wait cycles. `memr_n` and `iow_n` stay high.
- R4: Kind 2 (DMA read) pulls `memr_n` low in the second and third phases and in any wait cycles. It pulls `iow_n` low in the third phase and in any wait cycles. `memw_n` and `ior_n` stay high.
- R5: Each clock edge during the third or wait phase at which `ready` is low adds one wait cycle, and the strobes are held unchanged during it. The fourth phase releases every strobe.
- R6: Kind 0 (verify) asserts no strobe and ignores `ready`, so every word takes exactly four cycles. Its addresses and count still advance.
- R7: Kind 3 (memory copy) runs a read pass followed by a write pass for each word.
  - Read pass: it uses the source address and asserts `memr_n` in phases 2 and 3. `db_in` is captured on the edge that leaves phase 3 or the wait phase.
  - Write pass: it uses the destination address and asserts `memw_n` in phase 3. It drives the captured byte on `db_out`, with `db_oe` high, from phase 2 to phase 4.
- R8: After each word, the source and destination addresses step by +1 when `addr_down` is 0 and by -1 when it is 1. The step wraps modulo 2^16.
- R9: A word count of N transfers N+1 words. `tc` is high only in the final release phase of the last word, and the block is idle on the next cycle.
- R10: `io_oe` is 1 exactly while `busy` is 1. While idle, no strobe is driven low.
- R11: `start` and the transfer inputs are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| start | input | 1 | Begin a transfer; sampled only while idle |
| xfer_kind | input | 2 | 0 verify, 1 DMA write, 2 DMA read, 3 memory copy |
| addr_down | input | 1 | 1: addresses decrement per word |
| src_addr | input | 16 | Starting (source) address |
| dst_addr | input | 16 | Destination address for memory copy |
| word_count | input | 16 | Number of words minus one |
| ready | input | 1 | Low inserts wait cycles |
| db_in | input | 8 | Data bus input (copy read pass) |
| addr_lo | output | 8 | Low address byte |
| db_out | output | 8 | Data bus output: high address byte or copy data |
| db_oe | output | 1 | Data bus output enable |
| adstb | output | 1 | High-address latch strobe |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| io_oe | output | 1 | Output enable for the I/O strobe lines |
| busy | output | 1 | Transfer in progress |
| tc | output | 1 | Terminal count, final release phase |

## Verification
The assertions assume that `ready` is a clean synchronous level. They also assume that `start` is considered only while idle, so any stimulus given while busy must leave the running transfer untouched. The bench changes every input at the falling clock edge only. It toggles `ready` only in the third and wait phases, and it also holds `ready` low during verify to show that `ready` has no effect in that mode. The sweep covers every transfer kind, both address directions, counts of zero to two and zero to two wait cycles. It uses start addresses that make the high byte carry, borrow and wrap.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_S1   = 3'd1,
        ST_S2   = 3'd2,
        ST_S3   = 3'd3,
        ST_SW   = 3'd4,
        ST_S4   = 3'd5
    } dxs_state_e;

    typedef enum logic [1:0] {
        XF_VERIFY = 2'd0,
        XF_WRITE  = 2'd1,
        XF_READ   = 2'd2,
        XF_M2M    = 2'd3
    } dxs_kind_e;

    typedef struct packed {
        logic memr;
        logic memw;
        logic ior;
        logic iow;
    } dxs_strb_t;

endpackage

// File: rtl/dxs_step.sv
module dxs_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         down,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (down) nxt = val - ONE;
        else      nxt = val + ONE;
    end
endmodule

// File: rtl/dxs_strobe_dec.sv
module dxs_strobe_dec
    import dxs_pkg::*;
(
    input  dxs_state_e st,
    input  dxs_kind_e  kind,
    input  logic       wr_ph,
    output dxs_strb_t  strb
);
    logic rd_on;
    logic wr_on;

    always_comb begin
        rd_on = (st == ST_S2) || (st == ST_S3) || (st == ST_SW);
        wr_on = (st == ST_S3) || (st == ST_SW);
        strb  = '0;
        unique case (kind)
            XF_WRITE: begin
                strb.ior  = rd_on;
                strb.memw = wr_on;
            end
            XF_READ: begin
                strb.memr = rd_on;
                strb.iow  = wr_on;
            end
            XF_M2M: begin
                if (wr_ph) strb.memw = wr_on;
                else       strb.memr = rd_on;
            end
            default: strb = '0;
        endcase
    end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dxs_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int CNT_W  = 16,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        xfer_kind,
    input  logic              addr_down,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              ready,
    input  logic [DATA_W-1:0] db_in,
    output logic [DATA_W-1:0] addr_lo,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    output logic              adstb,
    output logic              memr_n,
    output logic              memw_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              io_oe,
    output logic              busy,
    output logic              tc
);
    localparam int NPTR = 2;

    typedef struct packed {
        dxs_state_e        st;
        dxs_kind_e         kind;
        logic              dec;
        logic              wr_ph;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] tmp;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0] ptr_cur [NPTR];
    logic [ADDR_W-1:0] ptr_nxt [NPTR];
    logic [CNT_W-1:0]  cnt_nxt;
    logic [ADDR_W-1:0] cur_addr;
    logic              last_ph;
    logic              cnt_zero;
    dxs_strb_t         strb;
    dxs_state_e        st_w;
    dxs_kind_e         kind_w;

    assign ptr_cur[0] = seq_q.src;
    assign ptr_cur[1] = seq_q.dst;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dxs_step #(.W(ADDR_W)) u_step (
            .val  (ptr_cur[g]),
            .down (seq_q.dec),
            .nxt  (ptr_nxt[g])
        );
    end

    dxs_step #(.W(CNT_W)) u_cnt (
        .val  (seq_q.cnt),
        .down (1'b1),
        .nxt  (cnt_nxt)
    );

    dxs_strobe_dec u_strb (
        .st    (seq_q.st),
        .kind  (seq_q.kind),
        .wr_ph (seq_q.wr_ph),
        .strb  (strb)
    );

    always_comb begin
        last_ph  = (seq_q.kind != XF_M2M) || seq_q.wr_ph;
        cnt_zero = (seq_q.cnt == '0);
        seq_d    = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st    = ST_S1;
                    seq_d.kind  = dxs_kind_e'(xfer_kind);
                    seq_d.dec   = addr_down;
                    seq_d.wr_ph = 1'b0;
                    seq_d.src   = src_addr;
                    seq_d.dst   = dst_addr;
                    seq_d.cnt   = word_count;
                end
            end
            ST_S1: seq_d.st = ST_S2;
            ST_S2: seq_d.st = ST_S3;
            ST_S3, ST_SW: begin
                if (ready || (seq_q.kind == XF_VERIFY)) begin
                    seq_d.st = ST_S4;
                    if ((seq_q.kind == XF_M2M) && !seq_q.wr_ph) seq_d.tmp = db_in;
                end else begin
                    seq_d.st = ST_SW;
                end
            end
            ST_S4: begin
                if (last_ph) begin
                    seq_d.src   = ptr_nxt[0];
                    seq_d.dst   = ptr_nxt[1];
                    seq_d.cnt   = cnt_nxt;
                    seq_d.wr_ph = 1'b0;
                    seq_d.st    = cnt_zero ? ST_IDLE : ST_S1;
                end else begin
                    seq_d.wr_ph = 1'b1;
                    seq_d.st    = ST_S1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    always_comb begin
        cur_addr = seq_q.wr_ph ? seq_q.dst : seq_q.src;
        addr_lo  = cur_addr[DATA_W-1:0];
        adstb    = (seq_q.st == ST_S1);
        db_oe    = adstb ||
                   ((seq_q.kind == XF_M2M) && seq_q.wr_ph && (seq_q.st != ST_IDLE));
        db_out   = adstb ? cur_addr[ADDR_W-1:DATA_W] : seq_q.tmp;
        busy     = (seq_q.st != ST_IDLE);
        io_oe    = busy;
        tc       = (seq_q.st == ST_S4) && last_ph && cnt_zero;
        memr_n   = ~strb.memr;
        memw_n   = ~strb.memw;
        ior_n    = ~strb.ior;
        iow_n    = ~strb.iow;
    end

    assign st_w   = seq_q.st;
    assign kind_w = seq_q.kind;

endmodule

// File: rtl/dxs_checker.sv
module dxs_checker
    import dxs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input dxs_state_e st,
    input dxs_kind_e  kind,
    input logic       busy,
    input logic       io_oe,
    input logic       db_oe,
    input logic       adstb,
    input logic       memr_n,
    input logic       memw_n,
    input logic       ior_n,
    input logic       iow_n,
    input logic       tc
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!io_oe && !db_oe && !adstb && memr_n && memw_n && ior_n && iow_n)); // R10
    AST_ADSTB_PULSE: assert property (@(posedge clk) disable iff (rst)
        adstb |=> !adstb); // R2
    AST_ADSTB_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        adstb |-> (memr_n && memw_n && ior_n && iow_n)); // R2
    AST_IO_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!ior_n && !iow_n)); // R3
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!memr_n && !memw_n)); // R7
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SW) |-> $stable({memr_n, memw_n, ior_n, iow_n})); // R5
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_S4) |-> (memr_n && memw_n && ior_n && iow_n)); // R5
    AST_VERIFY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == XF_VERIFY) |-> (memr_n && memw_n && ior_n && iow_n && st != ST_SW)); // R6
    AST_TC_IDLE: assert property (@(posedge clk) disable iff (rst)
        tc |=> !busy); // R9
endmodule

bind dma_xfer_seq dxs_checker u_dxs_checker (
    .clk    (clk),
    .rst    (rst),
    .st     (st_w),
    .kind   (kind_w),
    .busy   (busy),
    .io_oe  (io_oe),
    .db_oe  (db_oe),
    .adstb  (adstb),
    .memr_n (memr_n),
    .memw_n (memw_n),
    .ior_n  (ior_n),
    .iow_n  (iow_n),
    .tc     (tc)
);

// File: tb/test_dma_xfer_seq.sv
module test_dma_xfer_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  xfer_kind = 2'd0;
    logic        addr_down = 1'b0;
    logic [15:0] src_addr = '0;
    logic [15:0] dst_addr = '0;
    logic [15:0] word_count = '0;
    logic        ready = 1'b1;
    logic [7:0]  db_in = '0;
    logic [7:0]  addr_lo, db_out;
    logic        db_oe, adstb, memr_n, memw_n, ior_n, iow_n, io_oe, busy, tc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dma_xfer_seq i_dma_xfer_seq (
        .clk(clk), .rst(rst), .start(start), .xfer_kind(xfer_kind),
        .addr_down(addr_down), .src_addr(src_addr), .dst_addr(dst_addr),
        .word_count(word_count), .ready(ready), .db_in(db_in),
        .addr_lo(addr_lo), .db_out(db_out), .db_oe(db_oe), .adstb(adstb),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
        .io_oe(io_oe), .busy(busy), .tc(tc)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // strobes given active-high as {memr, memw, ior, iow}
    task automatic chk_strb(string req, logic [3:0] exp);
        chk(req, "strobes", {~memr_n, ~memw_n, ~ior_n, ~iow_n}, exp);
    endtask

    task automatic chk_idle(string req);
        chk(req, "busy/io_oe/db_oe/adstb/tc", {busy, io_oe, db_oe, adstb, tc}, 5'b0);
        chk_strb(req, 4'b0000);
    endtask

    task automatic run_xfer(input logic [1:0] kind, input bit dn, input logic [15:0] s,
                            input logic [15:0] d, input int cnt, input int waits,
                            input logic [7:0] pat, input bit poke);
        logic [15:0] es = s;
        logic [15:0] ed = d;
        int nph = (kind == 2'd3) ? 2 : 1;
        @(negedge clk);
        start = 1'b1; xfer_kind = kind; addr_down = dn;
        src_addr = s; dst_addr = d; word_count = 16'(cnt); ready = 1'b1;
        for (int w = 0; w <= cnt; w++) begin
            for (int ph = 0; ph < nph; ph++) begin
                logic [15:0] cur = (ph == 1) ? ed : es;
                logic [3:0] rd_s, wr_s;
                logic [7:0] exp_tmp = pat ^ 8'(w);
                bit last = (ph == nph - 1);
                case (kind)
                    2'd1: begin rd_s = 4'b0010; wr_s = 4'b0100; end
                    2'd2: begin rd_s = 4'b1000; wr_s = 4'b0001; end
                    2'd3: begin
                        rd_s = (ph == 0) ? 4'b1000 : 4'b0000;
                        wr_s = (ph == 0) ? 4'b0000 : 4'b0100;
                    end
                    default: begin rd_s = 4'b0000; wr_s = 4'b0000; end
                endcase
                @(negedge clk);
                start = 1'b0;
                // address phase
                chk("R2", "adstb", adstb, 1'b1);
                chk("R2", "db_oe", db_oe, 1'b1);
                chk("R2", "db_out high byte", db_out, cur[15:8]);
                chk("R8", "addr_lo", addr_lo, cur[7:0]);
                chk_strb("R2", 4'b0000);
                chk("R10", "io_oe", {busy, io_oe}, 2'b11);
                @(negedge clk);
                if (poke && w == 0 && ph == 0) begin
                    start = 1'b1; src_addr = ~s; dst_addr = ~d; xfer_kind = ~kind;
                end
                chk("R2", "adstb low", adstb, 1'b0);
                chk_strb(kind == 2'd1 ? "R3" : kind == 2'd2 ? "R4" : kind == 2'd3 ? "R7" : "R6", rd_s);
                chk("R11", "addr_lo", addr_lo, cur[7:0]);
                @(negedge clk);
                chk_strb(kind == 2'd1 ? "R3" : kind == 2'd2 ? "R4" : kind == 2'd3 ? "R7" : "R6", rd_s | wr_s);
                if (kind == 2'd3 && ph == 1) begin
                    chk("R7", "copy data", {db_oe, db_out}, {1'b1, exp_tmp});
                end
                if (kind == 2'd3 && ph == 0) db_in = exp_tmp;
                ready = (waits == 0);
                if (kind != 2'd0) begin
                    for (int i = 0; i < waits; i++) begin
                        @(negedge clk);
                        chk_strb("R5", rd_s | wr_s);
                        chk("R5", "tc in wait", tc, 1'b0);
                        if (i == waits - 1) ready = 1'b1;
                    end
                end
                @(negedge clk);
                ready = 1'b1;
                db_in = 8'h00;
                if (poke) begin start = 1'b0; src_addr = s; dst_addr = d; xfer_kind = kind; end
                chk_strb("R5", 4'b0000);
                chk("R9", "tc", tc, (w == cnt && last) ? 1'b1 : 1'b0);
                chk("R6", "busy in release", busy, 1'b1);
                if (kind == 2'd3 && ph == 1) chk("R7", "copy data hold", db_out, exp_tmp);
                if (last) begin
                    es = dn ? es - 16'd1 : es + 16'd1;
                    ed = dn ? ed - 16'd1 : ed + 16'd1;
                end
            end
        end
        @(negedge clk);
        chk_idle("R9");
        chk("R10", "io_oe idle", io_oe, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1;
        chk_idle("R1");
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        for (int k = 0; k < 4; k++)
            for (int dn = 0; dn < 2; dn++)
                for (int c = 0; c < 3; c++)
                    for (int wt = 0; wt < 3; wt++)
                        run_xfer(2'(k), dn[0], dn ? 16'h1301 : 16'h12FE,
                                 dn ? 16'hA100 : 16'hA0FE, c, wt,
                                 8'(8'h3C + 8'(k * 16 + c)), 1'b0);

        // wrap of the address modulo 2^16
        run_xfer(2'd2, 1'b0, 16'hFFFF, 16'h0000, 1, 0, 8'h00, 1'b0);
        run_xfer(2'd3, 1'b1, 16'h0000, 16'hFFFF, 1, 1, 8'h81, 1'b0);

        // start and inputs changing during a transfer are ignored
        for (int k = 0; k < 4; k++)
            run_xfer(2'(k), 1'b0, 16'h4455, 16'h6677, 2, 1, 8'h5A, 1'b1);

        // reset in the middle of a transfer
        @(negedge clk);
        start = 1'b1; xfer_kind = 2'd1; src_addr = 16'h2000; word_count = 16'd5;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "busy before reset", busy, 1'b1);
        rst = 1'b1;
        #1;
        chk_idle("R1");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule